// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside an 8-bit microcontroller core and decides when the core is held in reset and which of its clocks run. It filters the external reset pin: the pin is brought into the oscillator domain through a short synchronizer. The internal reset is raised only once the pin has been seen high for a full qualification window of two machine cycles, each machine cycle being twelve oscillator periods. A shorter pulse, or a pulse broken by a low sample, leaves the core untouched.

The CPU selects a low-power mode by writing request bits into a small control register. The write that sets a request is the last thing the CPU does before its clock stops. In idle, only the CPU clock is gated. Peripherals keep clocking, and any enabled pending interrupt brings the CPU back. In power-down, both clocks and the oscillator run request drop. Interrupts are ignored, and only a qualified reset restarts the part. To make that possible, a high reset pin requests the oscillator back at once.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: The internal reset rises after the reset pin has been sampled high on 24 consecutive oscillator clocks. Synchronizer latency adds two clocks, so it is visible after the 26th clock edge counted from the first high sample. It stays high while the pin stays high.
- R2: If the pin goes low before the window completes, the count restarts from zero. A 23-clock pulse, or two 20-clock pulses split by one low clock, never raise the internal reset.
- R3: The internal reset falls three clock edges after the pin is sampled low.
- R4: A control write with bit 0 set and bit 1 clear enters idle from the next edge. In idle the CPU clock enable is 0, while the peripheral clock enable and oscillator run are 1.
- R5: In idle, a high interrupt-pending input restores the CPU clock enable one edge later.
- R6: While the internal reset is high, all three enables are 1. The reset leaves the block in run mode, with no mode bit set, whether it started in idle or in power-down.
- R7: A control write with bit 1 set enters power-down from the next edge. In power-down the CPU clock enable, the peripheral clock enable and oscillator run are all 0.
- R8: In power-down, the interrupt-pending input has no effect on any output.
- R9: In power-down, a high reset pin raises oscillator run two edges after it is first sampled. The clock enables stay 0 until the internal reset is qualified.
- R10: A control write with both bits 0 and 1 set selects power-down.
- R11: Control writes made while the CPU clock is stopped are ignored.
- R12: Control bits 7 to 2 have no effect; writing 0xFC leaves the block in run mode.
- R13: While the asynchronous power-on reset is active, all three enables are 1 and the internal reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| ctl_we_i | input | 1 | Control register write strobe from the CPU |
| ctl_wdata_i | input | 8 | Control write data; bit 0 idle request, bit 1 power-down request |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_run_o | output | 1 | Oscillator run request to the analog cell |
| int_rst_o | output | 1 | Qualified internal reset, active high |

## Verification
Reset qualification is driven with a pulse exactly one clock short of the window, a pulse exactly at the window, and two sub-window pulses split by a single low clock. Together these separate a correct count from an off-by-one, and a counter that clears on a low sample from one that only pauses. Mode entry is tried with the idle code, the power-down code, both bits together and upper bits only. This shows the bit decode and the power-down priority apart. Wake-up is tried with an interrupt and with the reset pin from each mode, plus writes and interrupts that must be ignored, which tells which exit each mode accepts.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2
  } pmc_mode_e;
endpackage

// File: rtl/pmc_pin_sync.sv
module pmc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int QUAL_CYC = 24,
  localparam int CNT_W = $clog2(QUAL_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_s_i,
  input  logic             osc_run_i,
  output logic             int_rst_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(QUAL_CYC);

  logic [CNT_W-1:0] cnt_q;

  // counts only while the oscillator runs; any low sample restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!pin_s_i)                   cnt_q <= '0;
    else if (osc_run_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign int_rst_o = (cnt_q == CntMax);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_rst_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_i,
  output pmc_mode_e         mode_o,
  output logic              idle_o,
  output logic              pd_o
);
  logic idle_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (int_rst_i) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (we_i && !idle_q && !pd_q) begin
      // a stalled CPU cannot write, so writes count only in run mode
      idle_q <= wdata_i[IDLE_BIT];
      pd_q   <= wdata_i[PD_BIT];
    end else if (idle_q && !pd_q && irq_i) begin
      idle_q <= 1'b0;
    end
  end

  always_comb begin
    if (pd_q)        mode_o = MODE_PD;
    else if (idle_q) mode_o = MODE_IDLE;
    else             mode_o = MODE_RUN;
  end

  assign idle_o = idle_q;
  assign pd_o   = pd_q;
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pmc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OSC_PER_MC = 12,
  parameter int RST_MC     = 2,
  parameter int SYNC_STG   = 2,
  parameter int IDLE_BIT   = 0,
  parameter int PD_BIT     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  input  logic              irq_pend_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_run_o,
  output logic              int_rst_o
);
  localparam int QUAL_CYC = OSC_PER_MC * RST_MC;
  localparam int CNT_W    = $clog2(QUAL_CYC + 1);

  logic             pin_s;
  logic             int_rst;
  logic [CNT_W-1:0] qual_cnt;
  pmc_mode_e        mode;
  logic             idle_bit, pd_bit;

  pmc_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rst_pin_i),
    .q_o    (pin_s)
  );

  pmc_rst_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_s_i   (pin_s),
    .osc_run_i (osc_run_o),
    .int_rst_o (int_rst),
    .cnt_o     (qual_cnt)
  );

  pmc_mode_ctrl #(
    .DATA_W   (DATA_W),
    .IDLE_BIT (IDLE_BIT),
    .PD_BIT   (PD_BIT)
  ) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_rst_i (int_rst),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_wdata_i),
    .irq_i     (irq_pend_i),
    .mode_o    (mode),
    .idle_o    (idle_bit),
    .pd_o      (pd_bit)
  );

  // reset forces every clock on; a high pin restarts the oscillator so it can be qualified
  assign cpu_clk_en_o = int_rst || (mode == MODE_RUN);
  assign per_clk_en_o = int_rst || (mode != MODE_PD);
  assign osc_run_o    = int_rst || pin_s || (mode != MODE_PD);
  assign int_rst_o    = int_rst;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int QUAL_CYC = 24,
  parameter int CNT_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pin_s,
  input logic             int_rst,
  input logic             idle_bit,
  input logic             pd_bit,
  input logic             irq,
  input logic             cpu_en,
  input logic             per_en,
  input logic [CNT_W-1:0] cnt
);
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(QUAL_CYC));

  a_r2_rise_needs_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_rst) |-> $past(pin_s));

  a_r2_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_s |=> cnt == '0);

  a_r5_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_bit && !pd_bit && irq && !int_rst |=> !idle_bit);

  a_r6_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst |=> !idle_bit && !pd_bit);

  a_r8_pd_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_bit && !int_rst |=> pd_bit);

  a_r7_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_bit && !int_rst |-> !cpu_en && !per_en);
endmodule

bind pwr_rst_ctrl pmc_checker #(
  .QUAL_CYC (QUAL_CYC),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pin_s    (pin_s),
  .int_rst  (int_rst),
  .idle_bit (idle_bit),
  .pd_bit   (pd_bit),
  .irq      (irq_pend_i),
  .cpu_en   (cpu_clk_en_o),
  .per_en   (per_clk_en_o),
  .cnt      (qual_cnt)
);

// File: tb/pwr_rst_ctrl_test.sv
module pwr_rst_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       irq = 1'b0;
  logic       cpu_en, per_en, osc_run, int_rst;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwr_rst_ctrl uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rst_pin_i    (pin),
    .ctl_we_i     (we),
    .ctl_wdata_i  (wdata),
    .irq_pend_i   (irq),
    .cpu_clk_en_o (cpu_en),
    .per_clk_en_o (per_en),
    .osc_run_o    (osc_run),
    .int_rst_o    (int_rst)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // outputs packed as {cpu, per, osc, rst}
  function automatic logic [31:0] outs();
    return {28'd0, cpu_en, per_en, osc_run, int_rst};
  endfunction

  task automatic wr(logic [7:0] d);
    we = 1'b1; wdata = d;
    step(1);
    we = 1'b0; wdata = 8'h00;
  endtask

  task automatic pin_reset();
    pin = 1'b1;
    step(30);
    pin = 1'b0;
    step(4);
  endtask

  task automatic t_por();
    step(1);
    chk("R13 por outputs", outs(), 32'hE);
    rst_n = 1'b1;
    step(2);
    chk("R13 after por", outs(), 32'hE);
  endtask

  task automatic t_qualify();
    pin = 1'b1;
    step(25);
    chk("R1 one edge short", int_rst, 0);
    step(1);
    chk("R1 qualified", outs(), 32'hF);
    step(10);
    chk("R1 held", int_rst, 1);
    pin = 1'b0;
    step(2);
    chk("R3 still high at 2", int_rst, 1);
    step(1);
    chk("R3 released at 3", outs(), 32'hE);
  endtask

  task automatic t_short();
    logic seen = 1'b0;
    pin = 1'b1;
    for (int i = 0; i < 23; i++) begin step(1); seen |= int_rst; end
    pin = 1'b0;
    for (int i = 0; i < 5; i++) begin step(1); seen |= int_rst; end
    chk("R2 23-clock pulse", seen, 0);
    seen = 1'b0;
    pin = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1); seen |= int_rst; end
    pin = 1'b0;
    step(1); seen |= int_rst;
    pin = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1); seen |= int_rst; end
    pin = 1'b0;
    for (int i = 0; i < 5; i++) begin step(1); seen |= int_rst; end
    chk("R2 split pulse", seen, 0);
  endtask

  task automatic t_idle();
    wr(8'h01);
    chk("R4 idle entry", outs(), 32'h6);
    step(5);
    chk("R4 idle holds", outs(), 32'h6);
    wr(8'h00);
    chk("R11 write in idle ignored", outs(), 32'h6);
    irq = 1'b1;
    step(1);
    irq = 1'b0;
    chk("R5 irq wakes idle", outs(), 32'hE);
    wr(8'h01);
    pin = 1'b1;
    step(26);
    chk("R6 reset from idle", outs(), 32'hF);
    pin = 1'b0;
    step(3);
    chk("R6 run after idle reset", outs(), 32'hE);
  endtask

  task automatic t_pd();
    wr(8'h02);
    chk("R7 pd entry", outs(), 32'h0);
    irq = 1'b1;
    step(3);
    chk("R8 irq ignored in pd", outs(), 32'h0);
    irq = 1'b0;
    wr(8'h00);
    chk("R11 write in pd ignored", outs(), 32'h0);
    pin = 1'b1;
    step(1);
    chk("R9 osc still off at 1", osc_run, 0);
    step(1);
    chk("R9 osc restart", outs(), 32'h2);
    step(24);
    chk("R6 reset from pd", outs(), 32'hF);
    pin = 1'b0;
    step(3);
    chk("R6 run after pd reset", outs(), 32'hE);
  endtask

  task automatic t_both();
    wr(8'h03);
    chk("R10 both bits give pd", outs(), 32'h0);
    pin_reset();
    chk("R10 recovered", outs(), 32'hE);
  endtask

  task automatic t_upper();
    wr(8'hFC);
    chk("R12 upper bits ignored", outs(), 32'hE);
    step(3);
    chk("R12 still run", outs(), 32'hE);
  endtask

  initial begin
    t_por();
    t_qualify();
    t_short();
    t_idle();
    t_pd();
    t_both();
    t_upper();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule